// File: doc/BRIEF.md
# Scaled-Index Load Address Generator

This block forms the effective address of an indexed load whose index operand is scaled by a left shift before it is added to the base. It takes the base register contents, a flag telling whether the base register number is zero, the index register contents, a small shift immediate and a flag selecting the update form. It returns the effective address, a write-back enable with the value for the base register, and a flag marking an invalid encoding.

The scale is always one more than the encoded field, so a field of zero still doubles the index. In the plain forms a base register number of zero means a literal zero base. In the update forms the register contents are always used, and the computed address goes back into the base register. The arithmetic can be followed by one optional register stage, chosen by a parameter.

Top module: `scaled_ea_gen`

## Requirements
- R1: `ea` equals the base operand plus `index_val` shifted left by `sh_field + 1`, so the index is scaled by 2, 4, 8 or 16 for the default 2-bit field.
- R2: In a plain form (`upd_mode` = 0) with `base_is_r0` = 1, the base operand is zero and `ea` is the scaled index alone.
- R3: In an update form (`upd_mode` = 1), the base operand is `base_val` whatever the value of `base_is_r0`.
- R4: An update form with `base_is_r0` = 0 raises `wb_en`, and `wb_val` equals `ea`.
- R5: A plain form never raises `wb_en`.
- R6: An update form with `base_is_r0` = 1 raises `bad_form` and keeps `wb_en` low.
- R7: With `OUT_REG` = 1, `out_valid`, `ea`, `wb_en`, `wb_val` and `bad_form` reflect the inputs sampled at the previous rising edge. Reset clears all of them to zero.
- R8: `wb_en` and `bad_form` are low in any cycle where `out_valid` is low.
- R9: The shift and the add wrap modulo 2^XLEN. Bits shifted out above bit XLEN-1 and the carry out of the add are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output stage |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operands are valid this cycle |
| base_val | input | XLEN | Base register contents |
| base_is_r0 | input | 1 | Base register number is zero |
| index_val | input | XLEN | Index register contents |
| sh_field | input | SHW | Encoded shift amount; the actual shift is this value plus one |
| upd_mode | input | 1 | 1 selects the update form |
| out_valid | output | 1 | Results are valid |
| ea | output | XLEN | Effective address |
| wb_en | output | 1 | Write `wb_val` to the base register |
| wb_val | output | XLEN | Value to write back to the base register |
| bad_form | output | 1 | Update form with a zero base register number |

## Verification
With the default output stage, every result belongs to the operands driven one rising edge earlier. The bench drives each operand set on a falling edge. It checks the outputs at the next falling edge against an expectation it computed when it drove those operands, so each result is compared in the one cycle it is due. Idle cycles are mixed into the stream to confirm that the enables drop with `out_valid`. The address is compared only in cycles where `out_valid` is high.

// File: rtl/scaled_ea_gen.sv
module scaled_ea_gen #(
  parameter int XLEN    = 64,
  parameter int SHW     = 2,
  parameter bit OUT_REG = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [XLEN-1:0] base_val,
  input  logic            base_is_r0,
  input  logic [XLEN-1:0] index_val,
  input  logic [SHW-1:0]  sh_field,
  input  logic            upd_mode,
  output logic            out_valid,
  output logic [XLEN-1:0] ea,
  output logic            wb_en,
  output logic [XLEN-1:0] wb_val,
  output logic            bad_form
);
  localparam int CNTW = SHW + 1;

  logic [CNTW-1:0] amt;
  logic [XLEN-1:0] base_op, scaled, sum;
  logic            c_wb, c_bad;

  assign amt     = {1'b0, sh_field} + CNTW'(1);
  assign base_op = (base_is_r0 && !upd_mode) ? '0 : base_val;
  assign scaled  = index_val << amt;
  assign sum     = base_op + scaled;
  assign c_wb    = in_valid & upd_mode & ~base_is_r0;
  assign c_bad   = in_valid & upd_mode & base_is_r0;

  generate
    if (OUT_REG) begin : g_reg
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          out_valid <= 1'b0;
          ea        <= '0;
          wb_en     <= 1'b0;
          wb_val    <= '0;
          bad_form  <= 1'b0;
        end else begin
          out_valid <= in_valid;
          wb_en     <= c_wb;
          bad_form  <= c_bad;
          if (in_valid) begin
            ea     <= sum;
            wb_val <= sum;
          end
        end
      end

      a_r7_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
      a_r7_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
      a_r2_zero_base: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !upd_mode && base_is_r0 && index_val == '0) |=> ea == '0);
      a_r3_base_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && upd_mode && index_val == '0) |=> ea == $past(base_val));
      a_r5_plain_no_wb: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !upd_mode) |=> !wb_en);
    end else begin : g_comb
      assign out_valid = in_valid;
      assign ea        = sum;
      assign wb_en     = c_wb;
      assign wb_val    = sum;
      assign bad_form  = c_bad;
    end
  endgenerate

  a_r6_bad_no_wb: assert property (@(posedge clk) disable iff (!rst_n)
    bad_form |-> !wb_en);
  a_r4_wb_is_ea: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> wb_val == ea);
  a_r8_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_en || bad_form) |-> out_valid);
endmodule

// File: tb/test_scaled_ea_gen.sv
module test_scaled_ea_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [63:0] base_val = '0;
  logic        base_is_r0 = 1'b0;
  logic [63:0] index_val = '0;
  logic [1:0]  sh_field = '0;
  logic        upd_mode = 1'b0;
  logic        out_valid, wb_en, bad_form;
  logic [63:0] ea, wb_val;

  int checks = 0;
  int errors = 0;

  logic        x_valid = 1'b0, x_wb = 1'b0, x_bad = 1'b0;
  logic [63:0] x_ea = '0;
  string       x_tag = "R1";

  always #2.5 clk = ~clk;

  scaled_ea_gen i_scaled_ea_gen (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .base_val(base_val),
    .base_is_r0(base_is_r0), .index_val(index_val), .sh_field(sh_field),
    .upd_mode(upd_mode), .out_valid(out_valid), .ea(ea), .wb_en(wb_en),
    .wb_val(wb_val), .bad_form(bad_form));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic compare();
    chk("R7", 64'(out_valid), 64'(x_valid));
    if (x_valid) begin
      chk(x_tag, ea, x_ea);
      chk(upd_mode_tag_wb(), 64'(wb_en), 64'(x_wb));
      chk("R6", 64'(bad_form), 64'(x_bad));
      if (x_wb) chk("R4", wb_val, x_ea);
    end else begin
      chk("R8", 64'(wb_en), 64'd0);
      chk("R8", 64'(bad_form), 64'd0);
    end
  endtask

  function automatic string upd_mode_tag_wb();
    return x_bad ? "R6" : (x_wb ? "R4" : "R5");
  endfunction

  task automatic step(input logic v, input logic [63:0] b, input logic r0,
                      input logic [63:0] ix, input logic [1:0] sh, input logic up,
                      input string tag);
    @(negedge clk);
    compare();
    in_valid = v; base_val = b; base_is_r0 = r0;
    index_val = ix; sh_field = sh; upd_mode = up;
    x_valid = v;
    x_ea    = ((r0 && !up) ? 64'd0 : b) + (ix << (int'(sh) + 1));
    x_wb    = v && up && !r0;
    x_bad   = v && up && r0;
    x_tag   = tag;
  endtask

  initial begin
    #20000;
    errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R7", 64'(out_valid), 64'd0);
    chk("R7", ea, 64'd0);
    chk("R7", 64'(wb_en), 64'd0);
    chk("R7", 64'(bad_form), 64'd0);
    rst_n = 1'b1;
    step(1'b1, 64'h1000, 1'b0, 64'h3, 2'd0, 1'b0, "R1");
    step(1'b1, 64'h1000, 1'b0, 64'h3, 2'd3, 1'b0, "R1");
    step(1'b1, 64'hAAAA, 1'b1, 64'h5, 2'd1, 1'b0, "R2");
    step(1'b1, 64'hBEEF, 1'b1, 64'h0, 2'd2, 1'b1, "R3");
    step(1'b1, 64'h2000, 1'b0, 64'h7, 2'd2, 1'b1, "R4");
    step(1'b0, 64'h2000, 1'b0, 64'h7, 2'd2, 1'b1, "R8");
    step(1'b1, 64'h1, 1'b0, 64'hC000_0000_0000_0001, 2'd1, 1'b0, "R9");
    step(1'b1, 64'hFFFF_FFFF_FFFF_FFF0, 1'b0, 64'h8, 2'd0, 1'b1, "R9");
    for (int i = 0; i < 400; i++) begin
      logic v, r0, up;
      v = ($urandom % 5) != 0; r0 = ($urandom % 3) == 0; up = $urandom % 2;
      step(v, {$urandom, $urandom}, r0, {$urandom, $urandom}, 2'($urandom),
           up, up ? "R3" : (r0 ? "R2" : "R1"));
    end
    step(1'b0, 64'd0, 1'b0, 64'd0, 2'd0, 1'b0, "R8");
    @(negedge clk);
    compare();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule